// File: doc/BRIEF.md
# Burst Beat Address Sequencer

This block produces the address for each beat of a short burst. The controller presents a base address together with a qualified access on a load cycle. From then on, each advance cycle moves the burst to its next beat. The upper address bits come from the load and do not change for the rest of the burst. The low bits step through the beats in one of two orders. In linear order the beat index is added to the start bits, and the sum wraps at the top. In interleaved order the start bits are XORed with the beat index.

The state is kept as the loaded base and a separate beat index, so both orders come from the same registers. The order input and the read/write type are captured on the load cycle and held until the next load. Advance cycles ignore the select and write inputs completely. When the clock enable is low, the block keeps all of its state. A load cycle without select ends the burst. Advance cycles after that keep the block idle until the next qualified load.

All pins are plain control and status pins. There is no handshake, so the block applies no back-pressure and never stalls its user. The caller stalls the block by pulling the clock enable low. The outputs come straight from registers and refer to the beat that was loaded or advanced on the last enabled edge.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `beat_vld_o` is 0, `addr_o` is 0 and `beat_idx_o` is 0.
- R2: An enabled edge with `adv_i`=0 and `sel_i`=1 is a load. After it, `addr_o` equals the `addr_i` that was presented, `beat_idx_o` is 0, `beat_vld_o` is 1, and `beat_wr_o` equals the `wr_i` that was presented.
- R3: With `order_i`=0 at load (linear order), the low BEAT_W bits at beat n are (start + n) mod 2^BEAT_W. For example, a start of 01 gives 01, 10, 11, 00.
- R4: With `order_i`=1 at load (interleaved order), the low bits at beat n are start XOR n. A start of 01 gives 01, 00, 11, 10, and a start of 10 gives 10, 11, 00, 01.
- R5: Each enabled advance during a valid burst adds one to `beat_idx_o`. Advancing past the last beat (beat 3 when BEAT_W=2) wraps back to beat 0 and the start address, and the burst stays valid.
- R6: An advance steps the burst even when `sel_i`=0 or `wr_i` changes. Neither input has any effect on an advance cycle.
- R7: `beat_wr_o` keeps the value captured at load for every beat of the burst.
- R8: When `clk_en_i`=0, `addr_o`, `beat_idx_o`, `beat_vld_o` and `beat_wr_o` hold their values, whatever the other inputs do, including a load pattern.
- R9: An enabled edge with `adv_i`=0 and `sel_i`=0 clears `beat_vld_o`. Later enabled advances leave `beat_vld_o` at 0 until a load.
- R10: A change of `order_i` in the middle of a burst has no effect. The order captured at load stays in force.
- R11: During a burst, `addr_o` bits above BEAT_W keep the value loaded with the base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | 1 = edge takes effect, 0 = hold all state |
| adv_i | input | 1 | 1 = advance to next beat, 0 = load / deselect |
| sel_i | input | 1 | Combined chip select, used only on load cycles |
| wr_i | input | 1 | Access type at load: 1 = write, 0 = read |
| order_i | input | 1 | Beat order at load: 0 = linear, 1 = interleaved |
| addr_i | input | ADDR_W | Base address presented on a load |
| addr_o | output | ADDR_W | Address of the current beat |
| beat_vld_o | output | 1 | Current beat belongs to an active burst |
| beat_wr_o | output | 1 | Access type latched for the current burst |
| beat_idx_o | output | BEAT_W | Beat number within the burst |

## Verification
The bench builds the block with ADDR_W=12 and BEAT_W=2. With these values every start value under both orders can be run in full, including the wrap on the fifth beat. Each burst uses a different non-zero upper field, so a burst that wrongly carries over or clears the upper bits shows up as a wrong address. The bench also covers mid-burst changes to select, write and order, clock-enable stalls that present a load pattern, and advances after a deselect.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clk_en_i,
  input  logic         adv_i,
  input  logic         sel_i,
  input  logic         wr_i,
  input  logic         order_i,
  output logic         load_o,
  output logic         step_o,
  output logic         active_o,
  output logic         wr_lat_o,
  output burst_order_e order_lat_o
);

  logic         active_q;
  logic         wr_q;
  burst_order_e order_q;
  logic         desel;

  assign load_o = clk_en_i && !adv_i && sel_i;
  assign desel  = clk_en_i && !adv_i && !sel_i;
  assign step_o = clk_en_i && adv_i && active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      order_q  <= ORD_LINEAR;
    end else if (load_o) begin
      active_q <= 1'b1;
      wr_q     <= wr_i;
      order_q  <= burst_order_e'(order_i);
    end else if (desel) begin
      active_q <= 1'b0;
    end
  end

  assign active_o    = active_q;
  assign wr_lat_o    = wr_q;
  assign order_lat_o = order_q;

  AST_DESEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_i && !adv_i && !sel_i) |=> !active_o); // R9
  AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_i && adv_i && !active_o) |=> !active_o); // R9
  AST_TYPE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_i && adv_i && active_o) |=> (wr_lat_o == $past(wr_lat_o))); // R7
  AST_ORDER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_i && adv_i && active_o) |=> (order_lat_o == $past(order_lat_o))); // R10
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_i |=> ($stable(active_o) && $stable(wr_lat_o))); // R8

endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [BEAT_W-1:0] beat_o
);

  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load_i) begin
      base_q <= addr_i;
      beat_q <= '0;
    end else if (step_i) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign base_o = base_q;
  assign beat_o = beat_q;

  AST_LOAD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (base_o == $past(addr_i) && beat_o == '0)); // R2
  AST_STEP_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (beat_o == BEAT_W'($past(beat_o) + 1'b1))); // R5
  AST_BASE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> $stable(base_o)); // R11

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  burst_order_e      order_i,
  output logic [BEAT_W-1:0] low_o
);

  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] xor_low;

  assign lin_low = start_i + beat_i;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor_bit
    assign xor_low[b] = start_i[b] ^ beat_i[b];
  end

  always_comb begin
    unique case (order_i)
      ORD_XOR: low_o = xor_low;
      default: low_o = lin_low;
    endcase
  end

  always_comb begin
    if (beat_i == '0) begin
      AST_BEAT0_IS_START: assert (low_o == start_i); // R3
    end
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_i,
  input  logic              adv_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              beat_vld_o,
  output logic              beat_wr_o,
  output logic [BEAT_W-1:0] beat_idx_o
);

  localparam int HI_W = ADDR_W - BEAT_W;

  logic              load;
  logic              step;
  logic              active;
  logic              wr_lat;
  burst_order_e      order_lat;
  logic [ADDR_W-1:0] base;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] low;

  burst_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en_i   (clk_en_i),
    .adv_i      (adv_i),
    .sel_i      (sel_i),
    .wr_i       (wr_i),
    .order_i    (order_i),
    .load_o     (load),
    .step_o     (step),
    .active_o   (active),
    .wr_lat_o   (wr_lat),
    .order_lat_o(order_lat)
  );

  burst_seq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(load),
    .step_i(step),
    .addr_i(addr_i),
    .base_o(base),
    .beat_o(beat)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start_i(base[BEAT_W-1:0]),
    .beat_i (beat),
    .order_i(order_lat),
    .low_o  (low)
  );

  assign addr_o     = {base[ADDR_W-1:BEAT_W], low};
  assign beat_vld_o = active;
  assign beat_wr_o  = wr_lat;
  assign beat_idx_o = beat;

  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_i && adv_i && beat_vld_o) |=>
      (addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]))); // R11
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_i |=> ($stable(addr_o) && $stable(beat_vld_o) && $stable(beat_idx_o))); // R8
  AST_LOAD_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_i && !adv_i && sel_i) |=> (beat_vld_o && addr_o == $past(addr_i))); // R2
  AST_ADV_IGNORES_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_i && adv_i && beat_vld_o) |=> beat_vld_o); // R6

  if (HI_W < 1) begin : g_bad_width
    initial AST_WIDTH_OK: assert (0);
  end

endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

  localparam int AW = 12;
  localparam int BW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_en_i = 1'b0;
  logic          adv_i = 1'b0;
  logic          sel_i = 1'b0;
  logic          wr_i = 1'b0;
  logic          order_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;
  logic          beat_vld_o;
  logic          beat_wr_o;
  logic [BW-1:0] beat_idx_o;

  int checks = 0;
  int failures = 0;

  burst_addr_gen #(.ADDR_W(AW), .BEAT_W(BW)) i_burst_addr_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en_i  (clk_en_i),
    .adv_i     (adv_i),
    .sel_i     (sel_i),
    .wr_i      (wr_i),
    .order_i   (order_i),
    .addr_i    (addr_i),
    .addr_o    (addr_o),
    .beat_vld_o(beat_vld_o),
    .beat_wr_o (beat_wr_o),
    .beat_idx_o(beat_idx_o)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] ref_low(input logic [BW-1:0] s, input int n, input logic ord);
    logic [BW-1:0] nb;
    nb = BW'(n);
    return ord ? (s ^ nb) : BW'(s + nb);
  endfunction

  // drive one cycle: inputs set after a falling edge, checked after the next one
  task automatic cyc(input logic en, input logic adv, input logic sel, input logic wr,
                     input logic ord, input logic [AW-1:0] a);
    clk_en_i = en; adv_i = adv; sel_i = sel; wr_i = wr; order_i = ord; addr_i = a;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 vld", int'(beat_vld_o), 0);
    chk("R1 addr", int'(addr_o), 0);
    chk("R1 idx", int'(beat_idx_o), 0);
  endtask

  task automatic t_sweep();
    for (int ord = 0; ord < 2; ord++) begin
      for (int s = 0; s < 4; s++) begin
        logic [AW-BW-1:0] hi;
        hi = (AW-BW)'(10'h155 + 37 * (ord * 4 + s));
        cyc(1, 0, 1, s[0], ord[0], {hi, BW'(s)});
        chk("R2 vld", int'(beat_vld_o), 1);
        chk("R2 addr", int'(addr_o), int'({hi, BW'(s)}));
        chk("R2 wr", int'(beat_wr_o), s % 2);
        for (int n = 1; n < 5; n++) begin
          cyc(1, 1, 1, 0, ord[0], '0);
          chk(ord ? "R4 low" : "R3 low", int'(addr_o[BW-1:0]), int'(ref_low(BW'(s), n, ord[0])));
          chk("R11 upper", int'(addr_o[AW-1:BW]), int'(hi));
          chk("R5 idx", int'(beat_idx_o), n % 4);
        end
        chk("R5 wrap to start", int'(addr_o[BW-1:0]), s);
      end
    end
  endtask

  task automatic t_adv_ignores();
    cyc(1, 0, 1, 1, 0, 12'h8A2);
    cyc(1, 1, 0, 0, 0, 12'h000);
    chk("R6 vld after adv with sel low", int'(beat_vld_o), 1);
    chk("R6 addr stepped", int'(addr_o), 12'h8A3);
    chk("R7 wr kept", int'(beat_wr_o), 1);
    cyc(1, 1, 0, 1, 0, 12'hFFF);
    chk("R6 addr stepped again", int'(addr_o), 12'h8A0);
    chk("R7 wr kept again", int'(beat_wr_o), 1);
  endtask

  task automatic t_hold();
    cyc(1, 0, 1, 0, 1, 12'h3C6);
    cyc(1, 1, 1, 0, 1, 12'h000);
    chk("R4 beat1 of 10", int'(addr_o), 12'h3C7);
    cyc(0, 0, 1, 1, 0, 12'h111);
    chk("R8 addr held", int'(addr_o), 12'h3C7);
    chk("R8 idx held", int'(beat_idx_o), 1);
    chk("R8 wr held", int'(beat_wr_o), 0);
    cyc(0, 0, 0, 0, 0, 12'h000);
    chk("R8 vld held", int'(beat_vld_o), 1);
    cyc(1, 1, 1, 0, 1, 12'h000);
    chk("R4 beat2 of 10 after stall", int'(addr_o), 12'h3C4);
  endtask

  task automatic t_deselect();
    cyc(1, 0, 1, 0, 0, 12'h440);
    cyc(1, 0, 0, 0, 0, 12'h777);
    chk("R9 deselect clears vld", int'(beat_vld_o), 0);
    cyc(1, 1, 1, 0, 0, 12'h000);
    chk("R9 advance while idle", int'(beat_vld_o), 0);
    cyc(1, 1, 1, 1, 0, 12'h000);
    chk("R9 still idle", int'(beat_vld_o), 0);
    cyc(1, 0, 1, 0, 0, 12'h901);
    chk("R9 reload valid", int'(beat_vld_o), 1);
    chk("R2 reload addr", int'(addr_o), 12'h901);
  endtask

  task automatic t_order_mid();
    cyc(1, 0, 1, 0, 0, 12'h5A1);
    cyc(1, 1, 1, 0, 1, 12'h000);
    chk("R10 linear kept (01->10)", int'(addr_o[BW-1:0]), 2);
    cyc(1, 0, 1, 0, 1, 12'h5A1);
    cyc(1, 1, 1, 0, 0, 12'h000);
    chk("R10 interleaved kept (01->00)", int'(addr_o[BW-1:0]), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sweep();
    t_adv_ignores();
    t_hold();
    t_deselect();
    t_order_mid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule